// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a synchronous memory shared by two fully independent ports, called left and right. Each port has its own clock and reset. It captures its address, its control inputs and its write data in registers on the rising clock edge. Either port may read or write any word in the same cycle as the other. Each port also has a burst address counter. From the captured controls, the counter picks the word that is accessed: the external address, address zero, the counter's current value, or that value plus one.

The parameter `PIPELINED` sets the read latency. With `PIPELINED=1`, an extra output register is added. With `PIPELINED=0`, read data comes out one stage earlier (flow-through). `ADDR_W` and `DATA_W` set the depth and the width. For example, a 16-bit address with 9-bit words is a valid setting.

Read results leave each port as a stream that has a valid flag but no ready input. The consumer cannot apply back-pressure: it must take every beat in the cycle where `*_rvalid` is high. Whenever `*_rvalid` is low, `*_rdata` is zero.

Top module: `dpram_burst`

## Requirements
- R1: While a port's reset is low, and after it is released, that port's `rvalid` is 0 and its `rdata` is 0. Its counter holds address 0, so the first hold access after reset uses word 0.
- R2: Inputs are captured at a rising edge k. With `PIPELINED=0`, the result of a read captured at edge k is on the outputs after edge k+1.
- R3: With `PIPELINED=1`, the result of a read captured at edge k is on the outputs after edge k+2.
- R4: The internal address is chosen from the captured controls in this priority order:
  - `zero`=1 selects 0;
  - otherwise `load`=1 selects the external address;
  - otherwise `step`=1 selects counter+1;
  - otherwise the counter value is used.
  The counter takes the internal address on every edge.
- R5: A counter reset costs no extra cycle. A read or write captured together with `zero`=1 is performed at word 0.
- R6: When `step`=1 and the counter holds the last address (2^ADDR_W-1), the internal address wraps to 0.
- R7: A port is selected only when `sel`=1 and `sel_n`=0. A deselected port writes nothing and gives `rvalid`=0. Its counter still updates.
- R8: In the same cycle that `oe`=0, the port drives `rvalid`=0 and `rdata`=0. When `oe`=1, `rvalid` is 1 exactly for results of selected cycles with `we`=0. Write cycles (`we`=1) produce no valid beat.
- R9: The two ports work independently. Both may access any words, including the same word, in the same cycle.
- R10: A write on one port and a read of the same word on the other port may be captured at the same edge. In that case the read returns the old contents. Reads captured from the next edge onward return the new data. The contents after simultaneous writes of the same word by both ports are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port asynchronous reset, active low |
| l_sel | input | 1 | Left select, active high |
| l_sel_n | input | 1 | Left select, active low |
| l_we | input | 1 | Left write (1) or read (0) |
| l_oe | input | 1 | Left output enable, acts in the current cycle |
| l_load | input | 1 | Left: use and load the external address |
| l_step | input | 1 | Left: counter increment enable |
| l_zero | input | 1 | Left: counter reset to word 0 |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read-data valid |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port asynchronous reset, active low |
| r_sel | input | 1 | Right select, active high |
| r_sel_n | input | 1 | Right select, active low |
| r_we | input | 1 | Right write (1) or read (0) |
| r_oe | input | 1 | Right output enable, acts in the current cycle |
| r_load | input | 1 | Right: use and load the external address |
| r_step | input | 1 | Right: counter increment enable |
| r_zero | input | 1 | Right: counter reset to word 0 |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read-data valid |

## Verification
A read whose inputs are captured at edge k is due after edge k+1 in flow-through mode and after edge k+2 in pipelined mode. The output enable, by contrast, masks the result in the cycle it is low. The bench drives each cycle's inputs just after an edge and computes the result from a reference model of the memory and both counters. It queues that result with its due cycle, which is two cycles later for flow-through and three for pipelined, counted from the cycle of driving. A monitor samples on the falling edge, compares each queued beat in its due cycle, and applies the output enable value present at that moment. One flow-through instance and one pipelined instance receive the same stimulus, so every beat is checked at both latencies.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  // Counter operation, resolved at capture time in fixed priority order.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;

  function automatic cnt_op_e pick_op(input logic zero, input logic load, input logic step);
    if (zero)      return CNT_ZERO;
    else if (load) return CNT_LOAD;
    else if (step) return CNT_STEP;
    else           return CNT_HOLD;
  endfunction

  // Captured per-port control.
  typedef struct packed {
    logic    ok;   // port selected
    logic    we;
    cnt_op_e op;
  } port_ctl_t;

endpackage

// File: rtl/dpb_port_front.sv
module dpb_port_front
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_n,
  input  logic              we,
  input  logic              load,
  input  logic              step,
  input  logic              zero,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [DATA_W-1:0] acc_wdata
);

  port_ctl_t         ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] cnt_q;

  // Input capture stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '{ok: 1'b0, we: 1'b0, op: CNT_HOLD};
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q.ok <= sel & ~sel_n;
      ctl_q.we <= we;
      ctl_q.op <= pick_op(zero, load, step);
      addr_q   <= addr;
      wdata_q  <= wdata;
    end
  end

  // Internal address selection; wrap comes from the ADDR_W-bit sum.
  always_comb begin
    unique case (ctl_q.op)
      CNT_ZERO: acc_addr = '0;
      CNT_LOAD: acc_addr = addr_q;
      CNT_STEP: acc_addr = cnt_q + ADDR_W'(1);
      default:  acc_addr = cnt_q;
    endcase
  end

  // Burst counter follows the internal address every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= acc_addr;
  end

  assign acc_wr    = ctl_q.ok & ctl_q.we;
  assign acc_rd    = ctl_q.ok & ~ctl_q.we;
  assign acc_wdata = wdata_q;

endmodule

// File: rtl/dpb_xor_store.sv
module dpb_xor_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_q,
  output logic              l_qv,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_q,
  output logic              r_qv
);

  // Each bank has a single writer; a word's value is the XOR of both banks.
  logic [DATA_W-1:0] bank_l [DEPTH];
  logic [DATA_W-1:0] bank_r [DEPTH];

  always_ff @(posedge l_clk) begin
    if (l_wr) bank_l[l_addr] <= l_wdata ^ bank_r[l_addr];
  end

  always_ff @(posedge r_clk) begin
    if (r_wr) bank_r[r_addr] <= r_wdata ^ bank_l[r_addr];
  end

  // Read registers: non-blocking update gives old data on a same-edge write.
  always_ff @(posedge l_clk or negedge l_rst_n) begin
    if (!l_rst_n) begin
      l_q  <= '0;
      l_qv <= 1'b0;
    end else begin
      l_qv <= l_rd;
      if (l_rd) l_q <= bank_l[l_addr] ^ bank_r[l_addr];
    end
  end

  always_ff @(posedge r_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      r_q  <= '0;
      r_qv <= 1'b0;
    end else begin
      r_qv <= r_rd;
      if (r_rd) r_q <= bank_l[r_addr] ^ bank_r[r_addr];
    end
  end

endmodule

// File: rtl/dpb_out_stage.sv
module dpb_out_stage #(
  parameter int DATA_W    = 9,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe,
  input  logic [DATA_W-1:0] in_d,
  input  logic              in_v,
  output logic [DATA_W-1:0] out_d,
  output logic              out_v
);

  logic [DATA_W-1:0] d_s;
  logic              v_s;

  generate
    if (PIPELINED) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_s <= '0;
          v_s <= 1'b0;
        end else begin
          d_s <= in_d;
          v_s <= in_v;
        end
      end
    end else begin : g_flow
      assign d_s = in_d;
      assign v_s = in_v;
    end
  endgenerate

  assign out_v = v_s & oe;
  assign out_d = out_v ? d_s : '0;

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 9,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic              l_sel,
  input  logic              l_sel_n,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_load,
  input  logic              l_step,
  input  logic              l_zero,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_sel,
  input  logic              r_sel_n,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_load,
  input  logic              r_step,
  input  logic              r_zero,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);

  logic [ADDR_W-1:0] l_acc_addr, r_acc_addr;
  logic              l_acc_wr, l_acc_rd, r_acc_wr, r_acc_rd;
  logic [DATA_W-1:0] l_acc_wdata, r_acc_wdata;
  logic [DATA_W-1:0] l_q, r_q;
  logic              l_qv, r_qv;

  dpb_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front_l (
    .clk(l_clk), .rst_n(l_rst_n), .sel(l_sel), .sel_n(l_sel_n), .we(l_we),
    .load(l_load), .step(l_step), .zero(l_zero), .addr(l_addr), .wdata(l_wdata),
    .acc_addr(l_acc_addr), .acc_wr(l_acc_wr), .acc_rd(l_acc_rd), .acc_wdata(l_acc_wdata)
  );

  dpb_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front_r (
    .clk(r_clk), .rst_n(r_rst_n), .sel(r_sel), .sel_n(r_sel_n), .we(r_we),
    .load(r_load), .step(r_step), .zero(r_zero), .addr(r_addr), .wdata(r_wdata),
    .acc_addr(r_acc_addr), .acc_wr(r_acc_wr), .acc_rd(r_acc_rd), .acc_wdata(r_acc_wdata)
  );

  dpb_xor_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .l_clk(l_clk), .l_rst_n(l_rst_n), .l_addr(l_acc_addr), .l_wr(l_acc_wr),
    .l_rd(l_acc_rd), .l_wdata(l_acc_wdata), .l_q(l_q), .l_qv(l_qv),
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_addr(r_acc_addr), .r_wr(r_acc_wr),
    .r_rd(r_acc_rd), .r_wdata(r_acc_wdata), .r_q(r_q), .r_qv(r_qv)
  );

  dpb_out_stage #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_out_l (
    .clk(l_clk), .rst_n(l_rst_n), .oe(l_oe), .in_d(l_q), .in_v(l_qv),
    .out_d(l_rdata), .out_v(l_rvalid)
  );

  dpb_out_stage #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_out_r (
    .clk(r_clk), .rst_n(r_rst_n), .oe(r_oe), .in_d(r_q), .in_v(r_qv),
    .out_d(r_rdata), .out_v(r_rvalid)
  );

endmodule

// File: rtl/dpb_chk.sv
module dpb_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 9,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              sel_n,
  input logic              we,
  input logic              oe,
  input logic              load,
  input logic              step,
  input logic              zero,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic [ADDR_W-1:0] acc_addr
);

  logic rd_req;
  assign rd_req = sel & ~sel_n & ~we;

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!rvalid && rdata == '0);
  end

  assert_zero_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> acc_addr == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !zero) |=> acc_addr == $past(addr));

  assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !zero) |=> acc_addr == ADDR_W'($past(acc_addr) + 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load && !zero) |=> acc_addr == $past(acc_addr));

  assert_oe_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!rvalid && rdata == '0));

  generate
    if (PIPELINED) begin : g_lat_pipe
      assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_req, 3));
    end else begin : g_lat_flow
      assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_req, 2));
    end
  endgenerate

endmodule

bind dpram_burst dpb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPELINED(PIPELINED)) chk_l_i (
  .clk(l_clk), .rst_n(l_rst_n), .sel(l_sel), .sel_n(l_sel_n), .we(l_we), .oe(l_oe),
  .load(l_load), .step(l_step), .zero(l_zero), .addr(l_addr), .rdata(l_rdata),
  .rvalid(l_rvalid), .acc_addr(l_acc_addr)
);

bind dpram_burst dpb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPELINED(PIPELINED)) chk_r_i (
  .clk(r_clk), .rst_n(r_rst_n), .sel(r_sel), .sel_n(r_sel_n), .we(r_we), .oe(r_oe),
  .load(r_load), .step(r_step), .zero(r_zero), .addr(r_addr), .rdata(r_rdata),
  .rvalid(r_rvalid), .acc_addr(r_acc_addr)
);

// File: tb/dpram_burst_tb_top.sv
module dpram_burst_tb_top;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic sel, sel_n, we, oe, load, step, zero;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } pin_t;

  typedef struct {
    int            due;
    bit            v;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  pin_t lp, rp;
  int   cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // index 0/1: flow-through left/right, 2/3: pipelined left/right
  logic          ov [4];
  logic [DW-1:0] od [4];

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0)) dut_ft_i (
    .l_clk(clk), .l_rst_n(rst_n), .l_sel(lp.sel), .l_sel_n(lp.sel_n), .l_we(lp.we),
    .l_oe(lp.oe), .l_load(lp.load), .l_step(lp.step), .l_zero(lp.zero),
    .l_addr(lp.addr), .l_wdata(lp.data), .l_rdata(od[0]), .l_rvalid(ov[0]),
    .r_clk(clk), .r_rst_n(rst_n), .r_sel(rp.sel), .r_sel_n(rp.sel_n), .r_we(rp.we),
    .r_oe(rp.oe), .r_load(rp.load), .r_step(rp.step), .r_zero(rp.zero),
    .r_addr(rp.addr), .r_wdata(rp.data), .r_rdata(od[1]), .r_rvalid(ov[1])
  );

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1)) dut_i (
    .l_clk(clk), .l_rst_n(rst_n), .l_sel(lp.sel), .l_sel_n(lp.sel_n), .l_we(lp.we),
    .l_oe(lp.oe), .l_load(lp.load), .l_step(lp.step), .l_zero(lp.zero),
    .l_addr(lp.addr), .l_wdata(lp.data), .l_rdata(od[2]), .l_rvalid(ov[2]),
    .r_clk(clk), .r_rst_n(rst_n), .r_sel(rp.sel), .r_sel_n(rp.sel_n), .r_we(rp.we),
    .r_oe(rp.oe), .r_load(rp.load), .r_step(rp.step), .r_zero(rp.zero),
    .r_addr(rp.addr), .r_wdata(rp.data), .r_rdata(od[3]), .r_rvalid(ov[3])
  );

  // Reference model
  logic [DW-1:0] mem_m [DEPTH];
  logic [AW-1:0] cnt_m [2];
  exp_t          q [4][$];
  string         tag = "R1";
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  function automatic pin_t mk(bit s, bit sn, bit we, bit oe, bit ld, bit st, bit z,
                              logic [AW-1:0] a, logic [DW-1:0] d);
    pin_t p;
    p.sel = s; p.sel_n = sn; p.we = we; p.oe = oe;
    p.load = ld; p.step = st; p.zero = z; p.addr = a; p.data = d;
    return p;
  endfunction

  function automatic pin_t idle();
    return mk(0, 1, 0, 1, 0, 0, 0, '0, '0);
  endfunction
  function automatic pin_t rd_at(logic [AW-1:0] a);   // load + read
    return mk(1, 0, 0, 1, 1, 0, 0, a, '0);
  endfunction
  function automatic pin_t wr_at(logic [AW-1:0] a, logic [DW-1:0] d);
    return mk(1, 0, 1, 1, 1, 0, 0, a, d);
  endfunction
  function automatic pin_t rd_hold();
    return mk(1, 0, 0, 1, 0, 0, 0, '0, '0);
  endfunction
  function automatic pin_t rd_step();
    return mk(1, 0, 0, 1, 0, 1, 0, '0, '0);
  endfunction
  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 37 + 11) % (1 << DW));
  endfunction

  function automatic logic [AW-1:0] next_ia(pin_t p, logic [AW-1:0] c);
    if (p.zero)      return '0;
    else if (p.load) return p.addr;
    else if (p.step) return c + AW'(1);
    else             return c;
  endfunction

  // Driver: applies one cycle on both ports and queues expected beats.
  task automatic step(input pin_t l, input pin_t r);
    pin_t          p [2];
    logic [AW-1:0] ia [2];
    bit            ok [2];
    bit            v [2];
    logic [DW-1:0] d [2];
    exp_t          e;
    @(posedge clk); #2;
    p[0] = l; p[1] = r;
    for (int i = 0; i < 2; i++) begin
      ia[i] = next_ia(p[i], cnt_m[i]);
      ok[i] = p[i].sel && !p[i].sel_n;
    end
    // same-word double writes are unspecified: keep them out of the stimulus
    if (ok[0] && ok[1] && p[0].we && p[1].we && ia[0] == ia[1]) p[1].we = 1'b0;
    for (int i = 0; i < 2; i++) begin
      cnt_m[i] = ia[i];
      v[i] = ok[i] && !p[i].we;
      d[i] = v[i] ? mem_m[ia[i]] : '0;
    end
    for (int i = 0; i < 2; i++)
      if (ok[i] && p[i].we) mem_m[ia[i]] = p[i].data;
    for (int i = 0; i < 2; i++) begin
      e.v = v[i]; e.d = d[i];
      e.due = cyc + 2; e.tag = {tag, "/R2"}; q[i].push_back(e);
      e.due = cyc + 3; e.tag = {tag, "/R3"}; q[2 + i].push_back(e);
    end
    lp = p[0]; rp = p[1];
  endtask

  // Monitor: compares each queued beat in its due cycle.
  always @(negedge clk) begin
    exp_t          e;
    bit            oe_now, ev;
    logic [DW-1:0] ed;
    for (int i = 0; i < 4; i++) begin
      while (q[i].size() > 0 && q[i][0].due <= cyc) begin
        e = q[i].pop_front();
        oe_now = (i % 2 == 0) ? lp.oe : rp.oe;
        ev = e.v && oe_now;
        ed = ev ? e.d : '0;
        n_chk++;
        if (ov[i] !== ev || od[i] !== ed) begin
          n_bad++;
          $display("FAIL %s out%0d cyc=%0d: got v=%0b d=%h expected v=%0b d=%h",
                   e.tag, i, cyc, ov[i], od[i], ev, ed);
        end
      end
    end
  end

  task automatic check_quiet(input string t);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      n_chk++;
      if (ov[i] !== 1'b0 || od[i] !== '0) begin
        n_bad++;
        $display("FAIL %s out%0d: got v=%0b d=%h expected v=0 d=0", t, i, ov[i], od[i]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no end expected end of stimulus");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    lp = idle(); rp = idle();
    cnt_m[0] = '0; cnt_m[1] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_quiet("R1");

    // Fill through the left counter: reset-write at 0, then increments.
    tag = "R5";
    step(mk(1, 0, 1, 1, 0, 0, 1, 8'd99, pat(0)), idle());
    tag = "R4";
    for (int a = 1; a < DEPTH; a++) step(mk(1, 0, 1, 1, 0, 1, 0, '0, pat(a)), idle());

    tag = "R6";                       // increment past the last word wraps to 0
    step(rd_step(), idle());
    tag = "R4";                       // hold twice at 0, right bursts from 100
    step(rd_hold(), rd_at(8'd100));
    step(rd_hold(), rd_step());
    step(rd_step(), rd_step());
    step(mk(1, 0, 0, 1, 1, 1, 1, 8'd77, '0), idle()); // reset beats load/step
    step(mk(1, 0, 0, 1, 1, 1, 0, 8'd77, '0), idle()); // load beats step
    step(rd_hold(), idle());

    tag = "R5";                       // write with counter reset lands at 0
    step(idle(), mk(1, 0, 1, 1, 0, 0, 1, 8'd5, 9'h1AA));
    step(idle(), rd_hold());

    tag = "R9";                       // both ports read the same and distinct words
    step(rd_at(8'd5), rd_at(8'd5));
    step(rd_at(8'd200), wr_at(8'd201, 9'h0F0));
    step(rd_at(8'd201), rd_at(8'd200));

    tag = "R7";                       // deselected writes are dropped
    step(mk(0, 0, 1, 1, 1, 0, 0, 8'd30, 9'h111), idle());
    step(mk(1, 1, 1, 1, 1, 0, 0, 8'd30, 9'h122), idle());
    step(rd_at(8'd30), idle());
    step(mk(0, 1, 0, 1, 1, 0, 0, 8'd40, '0), idle()); // deselected read, loads 40
    step(mk(0, 1, 0, 1, 0, 1, 0, '0, '0), idle());     // counter steps to 41
    step(rd_hold(), idle());

    tag = "R10";                      // write/read collisions in both directions
    step(wr_at(8'd50, 9'h055), rd_at(8'd50));
    step(idle(), rd_hold());
    step(rd_at(8'd60), wr_at(8'd60, 9'h166));
    step(rd_hold(), idle());

    tag = "R8";                       // output enable masks in its own cycle
    step(rd_at(8'd10), rd_at(8'd11));
    step(mk(0, 1, 0, 0, 0, 0, 0, '0, '0), idle());
    step(mk(0, 1, 0, 0, 0, 0, 0, '0, '0), mk(0, 1, 0, 0, 0, 0, 0, '0, '0));
    step(mk(0, 1, 0, 0, 0, 0, 0, '0, '0), mk(0, 1, 0, 0, 0, 0, 0, '0, '0));
    step(wr_at(8'd12, 9'h012), wr_at(8'd13, 9'h013)); // writes give no beat
    step(rd_at(8'd12), rd_at(8'd13));

    tag = "R1";                       // mid-run reset: counters back to 0
    repeat (4) step(idle(), idle());
    @(posedge clk); #2 rst_n = 1'b0;
    cnt_m[0] = '0; cnt_m[1] = '0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      n_chk++;
      if (ov[i] !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 in reset out%0d: got v=%0b expected v=0", i, ov[i]);
      end
    end
    @(posedge clk); #2 rst_n = 1'b1;
    check_quiet("R1");
    step(rd_hold(), rd_hold());

    tag = "R9";                       // random traffic on both ports
    for (int n = 0; n < 600; n++) begin
      pin_t a, b;
      a = mk($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
             $urandom_range(0, 5) != 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1),
             $urandom_range(0, 15) == 0, AW'($urandom), DW'($urandom));
      b = mk($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
             $urandom_range(0, 5) != 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1),
             $urandom_range(0, 15) == 0, AW'($urandom), DW'($urandom));
      step(a, b);
    end

    repeat (6) step(idle(), idle());
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule